// File: doc/BRIEF.md
# Optical Transmitter Drive and Spare-Routing Configuration Register

This block holds the digital settings for a multi-channel optical transmitter that has eight primary laser outputs and four spare outputs. For each of the twelve outputs it keeps an 8-bit drive-current code, which an analog DAC outside the block turns into laser current. It also controls a small crossbar. Every primary output always carries its own detector data input. Each spare output can be pointed at any one of the eight detector inputs, so the data of a broken primary channel can still leave the chip.

Settings arrive as a serial bit stream taken from the voted command output of the upstream receiver. A frame is 24 bits long and is shifted in most significant bit first. A strobe then commits it, and only a frame of exactly 24 bits takes effect. After reset every channel carries a nonzero default drive code and every spare output is idle, so the links run before any command arrives. Every stored bit is kept in three copies and read through a 2-of-3 vote. The vote result is written back to all three copies on every clock, which clears a single upset copy.

Top module: `optx_cfg_top`

## Requirements
- R1: After reset every drive code equals the parameter CODE_RST (default 0x50) and every spare output drives 0.
- R2: A committed frame with opcode bits [23:20] = 1 (set current) writes bits [7:0] into the drive code of the channel named by bits [19:16]. The bits enter most significant first, one per cycle while cfg_shift_i is high. The code appears on drive_code_o[8*ch +: 8].
- R3: A set-current frame changes channel ch only when write-enable bit [12 + (ch mod 4)] of the frame is 1. Otherwise no code changes.
- R4: A set-current frame whose channel field is above 11 changes no code. Channel 11 is still written.
- R5: A strobe commits only when exactly 24 bits were shifted since reset or since the previous strobe. Shorter and longer frames are dropped. A shift asserted in the same cycle as a strobe is ignored, and the bit count restarts from zero after every strobe.
- R6: A committed frame with opcode 2 (set route) stores bits [3:0] as the source of spare output s = bits [19:16]. Values of s above 3 are ignored.
- R7: Spare output s (tx_data_o[8+s]) carries det_data_i[src] when its source src is 0 to 7. It drives 0 when src is 15 (idle) or any value from 8 to 14.
- R8: Primary output i (tx_data_o[i]) always carries det_data_i[i], whatever the routing.
- R9: A committed frame with any opcode other than 1 or 2 changes no setting.
- R10: When any single copy of the triplicated storage is upset, the outputs do not change. The next clock restores the upset copy from the vote, so a later upset of a different copy is also tolerated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, loads the defaults |
| cfg_bit_i | input | 1 | Serial configuration bit |
| cfg_shift_i | input | 1 | Shifts cfg_bit_i into the frame register when high |
| cfg_strobe_i | input | 1 | Frame commit strobe |
| det_data_i | input | 8 | Detector data, one bit per primary channel |
| drive_code_o | output | 96 | Voted drive codes, 8 bits per output channel, channel 0 in the low byte |
| tx_data_o | output | 12 | Data toward outputs: [7:0] primaries, [11:8] spares |

## Verification
Random 24-bit frames are sent with biased opcodes, channel fields that cover the 0 to 15 range and random enable nibbles, mixed with frames of 23 and 25 bits. A reference model tracks every setting, so the checks separate writes that land on the right channel from writes that are wrongly gated or misplaced, and from wrong-length frames that were wrongly accepted. Several detector data patterns are applied for each routing, which shows whether a spare follows the selected input rather than some other input or a constant. Directed cases cover channel 11 against 12 to 15, idle and out-of-range sources, a strobe that coincides with a shift, and forced corruption of one storage copy after another.

// File: rtl/optx_cfg_pkg.sv
package optx_cfg_pkg;

    localparam int FRAME_W  = 24;
    localparam int OP_MSB   = 23;
    localparam int OP_LSB   = 20;
    localparam int SEL_MSB  = 19;
    localparam int SEL_LSB  = 16;
    localparam int WEN_MSB  = 15;
    localparam int WEN_LSB  = 12;
    localparam int VAL_MSB  = 7;
    localparam int VAL_LSB  = 0;
    localparam int FIELD_W  = 4;
    localparam int SRC_W    = 4;

    typedef enum logic [FIELD_W-1:0] {
        OP_SET_CUR   = 4'h1,
        OP_SET_ROUTE = 4'h2
    } cfg_op_e;

    localparam logic [SRC_W-1:0] SRC_IDLE = 4'hF;

endpackage

// File: rtl/optx_cfg_deser.sv
module optx_cfg_deser
    import optx_cfg_pkg::*;
#(
    parameter int LEN = FRAME_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bit_i,
    input  logic           shift_i,
    input  logic           strobe_i,
    output logic [LEN-1:0] frame_o,
    output logic           commit_o
);

    localparam int CNT_W   = $clog2(LEN + 2);
    localparam int CNT_SAT = LEN + 1;

    typedef struct packed {
        logic [LEN-1:0]   sh;
        logic [CNT_W-1:0] cnt;
    } des_t;

    des_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (strobe_i) begin
            st_d.cnt = '0;
        end else if (shift_i) begin
            st_d.sh = {st_q.sh[LEN-2:0], bit_i};
            if (st_q.cnt != CNT_W'(CNT_SAT)) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_o  = st_q.sh;
    assign commit_o = strobe_i && (st_q.cnt == CNT_W'(LEN));

    // R5: counting restarts after every strobe, even with a coincident shift
    a_r5_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> (st_q.cnt == '0));

    // R5: the counter never runs past its saturation value
    a_r5_count_sat: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(CNT_SAT));

endmodule

// File: rtl/optx_cfg_tmr_reg.sv
module optx_cfg_tmr_reg #(
    parameter int           W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] wr_mask_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] vote_o
);

    typedef struct packed {
        logic [W-1:0] c0;
        logic [W-1:0] c1;
        logic [W-1:0] c2;
    } trip_t;

    trip_t        st_d, st_q;
    logic [W-1:0] vote;
    logic [W-1:0] merged;

    always_comb begin
        vote   = (st_q.c0 & st_q.c1) | (st_q.c1 & st_q.c2) | (st_q.c0 & st_q.c2);
        merged = (vote & ~wr_mask_i) | (wr_data_i & wr_mask_i);
        st_d.c0 = merged;
        st_d.c1 = merged;
        st_d.c2 = merged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{c0: RST_VAL, c1: RST_VAL, c2: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign vote_o = vote;

    // R10: with no write the voted value holds, even with one copy upset
    a_r10_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mask_i == '0) |=> $stable(vote_o));

    // R10: bits outside the write mask keep their voted value
    a_r10_masked_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((vote_o & ~$past(wr_mask_i)) == ($past(vote_o) & ~$past(wr_mask_i))));

endmodule

// File: rtl/optx_cfg_xbar.sv
module optx_cfg_xbar
    import optx_cfg_pkg::*;
#(
    parameter int N_PRI = 8,
    parameter int N_SPR = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_PRI-1:0]       data_i,
    input  logic [N_SPR*SRC_W-1:0] src_i,
    output logic [N_PRI+N_SPR-1:0] out_o
);

    localparam int PSEL_W = $clog2(N_PRI);

    assign out_o[N_PRI-1:0] = data_i;

    for (genvar s = 0; s < N_SPR; s++) begin : g_spare
        logic [SRC_W-1:0] src;
        assign src = src_i[s*SRC_W +: SRC_W];

        always_comb begin
            if (src < SRC_W'(N_PRI)) begin
                out_o[N_PRI+s] = data_i[src[PSEL_W-1:0]];
            end else begin
                out_o[N_PRI+s] = 1'b0;
            end
        end

        // R7: an idle or out-of-range source gives a quiet spare
        a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (src >= SRC_W'(N_PRI)) |-> (out_o[N_PRI+s] == 1'b0));
    end

endmodule

// File: rtl/optx_cfg_top.sv
module optx_cfg_top
    import optx_cfg_pkg::*;
#(
    parameter int                N_PRI    = 8,
    parameter int                N_SPR    = 4,
    parameter int                CODE_W   = 8,
    parameter logic [CODE_W-1:0] CODE_RST = 8'h50
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_bit_i,
    input  logic                       cfg_shift_i,
    input  logic                       cfg_strobe_i,
    input  logic [N_PRI-1:0]           det_data_i,
    output logic [(N_PRI+N_SPR)*CODE_W-1:0] drive_code_o,
    output logic [N_PRI+N_SPR-1:0]     tx_data_o
);

    localparam int N_OUT  = N_PRI + N_SPR;
    localparam int CUR_W  = N_OUT * CODE_W;
    localparam int RT_W   = N_SPR * SRC_W;
    localparam int WEN_W  = WEN_MSB - WEN_LSB + 1;

    logic [FRAME_W-1:0] frame;
    logic               commit;
    logic [FIELD_W-1:0] fr_op, fr_sel;
    logic [WEN_W-1:0]   fr_wen;
    logic [CODE_W-1:0]  fr_val;
    logic [CUR_W-1:0]   cur_mask, cur_data, cur_vote;
    logic [RT_W-1:0]    rt_mask, rt_data, rt_vote;

    optx_cfg_deser #(.LEN(FRAME_W)) u_deser (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_i    (cfg_bit_i),
        .shift_i  (cfg_shift_i),
        .strobe_i (cfg_strobe_i),
        .frame_o  (frame),
        .commit_o (commit)
    );

    always_comb begin
        fr_op    = frame[OP_MSB:OP_LSB];
        fr_sel   = frame[SEL_MSB:SEL_LSB];
        fr_wen   = frame[WEN_MSB:WEN_LSB];
        fr_val   = frame[VAL_LSB +: CODE_W];
        cur_mask = '0;
        rt_mask  = '0;
        cur_data = {N_OUT{fr_val}};
        rt_data  = {N_SPR{fr_val[SRC_W-1:0]}};
        for (int ch = 0; ch < N_OUT; ch++) begin
            if (commit && fr_op == OP_SET_CUR && fr_sel == FIELD_W'(ch)
                && fr_wen[ch % WEN_W]) begin
                cur_mask[ch*CODE_W +: CODE_W] = '1;
            end
        end
        for (int s = 0; s < N_SPR; s++) begin
            if (commit && fr_op == OP_SET_ROUTE && fr_sel == FIELD_W'(s)) begin
                rt_mask[s*SRC_W +: SRC_W] = '1;
            end
        end
    end

    optx_cfg_tmr_reg #(
        .W       (CUR_W),
        .RST_VAL ({N_OUT{CODE_RST}})
    ) u_cur_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_mask_i (cur_mask),
        .wr_data_i (cur_data),
        .vote_o    (cur_vote)
    );

    optx_cfg_tmr_reg #(
        .W       (RT_W),
        .RST_VAL ({N_SPR{SRC_IDLE}})
    ) u_route_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_mask_i (rt_mask),
        .wr_data_i (rt_data),
        .vote_o    (rt_vote)
    );

    optx_cfg_xbar #(.N_PRI(N_PRI), .N_SPR(N_SPR)) u_xbar (
        .clk    (clk),
        .rst_n  (rst_n),
        .data_i (det_data_i),
        .src_i  (rt_vote),
        .out_o  (tx_data_o)
    );

    assign drive_code_o = cur_vote;

    // R2: an enabled set-current frame lands in the named channel
    a_r2_code_written: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && fr_op == OP_SET_CUR && fr_sel < FIELD_W'(N_OUT) && fr_wen[fr_sel[1:0]])
        |=> (drive_code_o[$past(fr_sel)*CODE_W +: CODE_W] == $past(fr_val)));

    // R4: a channel field past the last output leaves every code alone
    a_r4_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && fr_op == OP_SET_CUR && fr_sel >= FIELD_W'(N_OUT)) |=> $stable(drive_code_o));

    // R9: unknown opcodes leave all settings alone
    a_r9_unknown_op: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_op != OP_SET_CUR && fr_op != OP_SET_ROUTE) |=> ($stable(drive_code_o) && $stable(rt_vote)));

    // R6: a route frame stores the source nibble for the named spare
    a_r6_route_written: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && fr_op == OP_SET_ROUTE && fr_sel < FIELD_W'(N_SPR))
        |=> (rt_vote[$past(fr_sel)*SRC_W +: SRC_W] == $past(fr_val[SRC_W-1:0])));

endmodule

// File: tb/optx_cfg_top_tb_top.sv
module optx_cfg_top_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int N_PRI = 8;
    localparam int N_SPR = 4;
    localparam int N_OUT = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_bit = 1'b0;
    logic        cfg_shift = 1'b0;
    logic        cfg_strobe = 1'b0;
    logic [7:0]  det_data = 8'h00;
    logic [95:0] drive_code;
    logic [11:0] tx_data;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] exp_code [N_OUT];
    logic [3:0] exp_src  [N_SPR];

    always #2.5 clk = ~clk;

    optx_cfg_top dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_bit_i    (cfg_bit),
        .cfg_shift_i  (cfg_shift),
        .cfg_strobe_i (cfg_strobe),
        .det_data_i   (det_data),
        .drive_code_o (drive_code),
        .tx_data_o    (tx_data)
    );

    function automatic logic [95:0] code_vec();
        logic [95:0] v;
        for (int c = 0; c < N_OUT; c++) v[c*8 +: 8] = exp_code[c];
        return v;
    endfunction

    function automatic logic [11:0] tx_vec(input logic [7:0] d);
        logic [11:0] v;
        v[7:0] = d;
        for (int s = 0; s < N_SPR; s++) v[8+s] = (exp_src[s] < 4'd8) ? d[exp_src[s][2:0]] : 1'b0;
        return v;
    endfunction

    function automatic void model(input logic [23:0] f);
        logic [3:0] op, sel, wen;
        op = f[23:20]; sel = f[19:16]; wen = f[15:12];
        if (op == 4'h1 && sel < 4'd12 && wen[sel[1:0]]) exp_code[sel] = f[7:0];
        if (op == 4'h2 && sel < 4'd4) exp_src[sel] = f[3:0];
    endfunction

    task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_codes(input string tag);
        chk(tag, drive_code, code_vec());
    endtask

    task automatic chk_tx(input string tag, input logic [7:0] d);
        det_data = d;
        #1;
        chk(tag, {84'd0, tx_data}, {84'd0, tx_vec(d)});
    endtask

    task automatic send(input logic [31:0] bits, input int len, input bit shift_on_strobe);
        for (int i = len - 1; i >= 0; i--) begin
            @(negedge clk);
            cfg_shift = 1'b1;
            cfg_bit   = bits[i];
        end
        @(negedge clk);
        cfg_shift  = shift_on_strobe;
        cfg_bit    = 1'b1;
        cfg_strobe = 1'b1;
        @(negedge clk);
        cfg_shift  = 1'b0;
        cfg_strobe = 1'b0;
        @(negedge clk);
        if (len == 24) model(bits[23:0]);
    endtask

    function automatic logic [23:0] mk(input logic [3:0] op, input logic [3:0] sel,
                                        input logic [3:0] wen, input logic [7:0] val);
        return {op, sel, wen, 4'h0, val};
    endfunction

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int dummy;
        dummy = $urandom(32'd2718);
        for (int c = 0; c < N_OUT; c++) exp_code[c] = 8'h50;
        for (int s = 0; s < N_SPR; s++) exp_src[s] = 4'hF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        chk_codes("R1 reset codes");
        chk_tx("R1 R8 reset outputs", 8'hA5);
        chk_tx("R1 R8 reset outputs", 8'hFF);

        send(32'(mk(4'h1, 4'd5, 4'b0010, 8'h3C)), 24, 1'b0);
        chk_codes("R2 write ch5");
        send(32'(mk(4'h1, 4'd6, 4'b1011, 8'h11)), 24, 1'b0);
        chk_codes("R3 write ch6 without enable bit 2");
        send(32'(mk(4'h1, 4'd13, 4'hF, 8'h22)), 24, 1'b0);
        chk_codes("R4 channel 13 ignored");
        send(32'(mk(4'h1, 4'd11, 4'b1000, 8'hE7)), 24, 1'b0);
        chk_codes("R4 channel 11 written");
        send(32'(mk(4'h1, 4'd0, 4'hF, 8'h99)) >> 1, 23, 1'b0);
        chk_codes("R5 23-bit frame dropped");
        send({7'd0, 1'b1, mk(4'h1, 4'd1, 4'hF, 8'h77)}, 25, 1'b0);
        chk_codes("R5 25-bit frame dropped");
        send(32'(mk(4'h1, 4'd2, 4'hF, 8'h6B)), 24, 1'b1);
        chk_codes("R5 strobe with shift commits");
        send(32'(mk(4'h1, 4'd3, 4'hF, 8'h01)), 24, 1'b0);
        chk_codes("R5 count restarted after strobe");
        send(32'(mk(4'h3, 4'd0, 4'hF, 8'h00)), 24, 1'b0);
        chk_codes("R9 unknown opcode");
        send(32'(mk(4'h2, 4'd2, 4'h0, 8'h03)), 24, 1'b0);
        chk_tx("R6 R7 spare2 from input3", 8'h08);
        chk_tx("R6 R7 spare2 from input3", 8'hF7);
        send(32'(mk(4'h2, 4'd1, 4'h0, 8'h09)), 24, 1'b0);
        chk_tx("R7 source 9 quiet", 8'hFF);
        send(32'(mk(4'h2, 4'd6, 4'h0, 8'h00)), 24, 1'b0);
        chk_tx("R6 spare field 6 ignored", 8'h01);
        send(32'(mk(4'h2, 4'd0, 4'h0, 8'h07)), 24, 1'b0);
        chk_tx("R6 R8 spare0 from input7", 8'h80);
        chk_tx("R8 primaries pass", 8'h5A);

        // R10: upset one copy, then another after a scrub cycle
        @(negedge clk);
        force dut_i.u_cur_store.st_q = {96'd0, code_vec(), code_vec()};
        #1;
        chk_codes("R10 copy0 upset");
        @(negedge clk);
        release dut_i.u_cur_store.st_q;
        @(negedge clk);
        @(negedge clk);
        force dut_i.u_cur_store.st_q = {code_vec(), ~code_vec(), code_vec()};
        #1;
        chk_codes("R10 copy1 upset after scrub");
        @(negedge clk);
        release dut_i.u_cur_store.st_q;
        @(negedge clk);
        @(negedge clk);
        chk_codes("R10 settled");

        for (int it = 0; it < 300; it++) begin
            logic [3:0]  op, sel, wen;
            logic [7:0]  val;
            logic [23:0] f;
            int          k, len;
            k   = $urandom_range(0, 9);
            op  = (k < 5) ? 4'h1 : (k < 8) ? 4'h2 : 4'($urandom_range(0, 15));
            sel = 4'($urandom_range(0, 15));
            wen = 4'($urandom_range(0, 15));
            val = 8'($urandom_range(0, 255));
            f   = mk(op, sel, wen, val);
            k   = $urandom_range(0, 9);
            len = (k == 0) ? 23 : (k == 1) ? 25 : 24;
            send((len == 25) ? {7'd0, 1'b0, f} : (len == 23) ? 32'(f) >> 1 : 32'(f), len, 1'b0);
            if (len != 24) chk_codes("R5 random bad length");
            else if (op == 4'h1) chk_codes("R2 R3 R4 random write");
            else chk_codes("R9 random other op");
            chk_tx("R6 R7 R8 random routing", 8'($urandom_range(0, 255)));
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule